// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block moves received frames from a byte stream into memory under the control of a ring of buffer descriptors. The memory is word-addressed and 32 bits wide. Each descriptor takes two consecutive words. The first word carries a 16-bit status half in bits 31:16 and a 16-bit length half in bits 15:0. The second word is a 32-bit byte pointer to the frame buffer.

Software gives a descriptor to the engine by setting its EMPTY flag. It then pulses `act_set` to start or resume the engine. The engine fetches a descriptor ahead of time, so it is ready before a frame begins. It packs the frame bytes little-endian into the buffer, using byte enables for a partial final word. When the frame ends, it writes back the length and then the status, and steps to the next descriptor.

If the descriptor it fetches is still owned by software, the engine drops its active flag and waits. Until the next `act_set`, every frame that arrives is discarded and counted. Taking `ctrl_en` low stops the engine and puts the descriptor index back at the ring base.

Buffer pointers must be word aligned and `buf_size` must be a multiple of 4. The memory must return read data one cycle after the request and must accept every request at once.

Top module: `rx_ring_dma`

## Requirements
- R1: After reset, `act` is 0, `drop_cnt` is 0 and `mem_req` is 0.
- R2: After `act_set`, the engine reads the descriptor at `ring_base`. If status bit 15 (EMPTY, word bit 31) is set, it reads the pointer word and raises `act`. Frame byte k is stored at word `ptr/4 + k/4`, byte lane `k%4`. Only the bytes received are enabled.
- R3: At frame end, the stored byte count (FCS bytes included) goes to the low half of the descriptor (byte enables 0011). The status is then written to the high half (byte enables 1100) in the very next cycle. The status write is the last memory write for that descriptor.
- R4: The written status has EMPTY cleared and LAST (bit 11) set. WRAP (bit 13) keeps its fetched value. ERR (bit 2) is set if `rx_err` came with any byte of the frame.
- R5: The next descriptor lies two words further on. If WRAP was set, the next descriptor is at `ring_base` instead.
- R6: If the fetched descriptor is not EMPTY, `act` clears and nothing is written. The engine stays idle until `act_set`, and then it fetches the same descriptor again.
- R7: A frame whose first byte arrives while the engine is not ready writes nothing to memory. `drop_cnt` increases by 1 at its last byte. The frame stays dropped even if the engine becomes ready before its last byte.
- R8: Bytes beyond `buf_size` are not stored. In that case the length is `buf_size` and TRUNC (status bit 0) is set.
- R9: LONG (status bit 5) is set when the frame has more than `max_flen` bytes. This limit alone does not truncate the frame. Software normally programs 1518.
- R10: While `ctrl_en` is 0, `act` is 0 and no memory request is made. Frames are ignored and not counted. After re-enabling and `act_set`, the next frame lands in the descriptor at `ring_base`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_en | input | 1 | Controller enable; low resets the ring index |
| act_set | input | 1 | Pulse: start or resume descriptor processing |
| ring_base | input | AW | Word address of the first descriptor |
| buf_size | input | 16 | Maximum bytes stored per descriptor (multiple of 4) |
| max_flen | input | 16 | Frame length above which LONG is flagged |
| rx_valid | input | 1 | Byte valid on the receive stream |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Marks the last byte of a frame |
| rx_err | input | 1 | Marks the frame as bad |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when 1, read when 0 |
| mem_addr | output | AW | Word address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read request |
| act | output | 1 | Engine active flag |
| drop_cnt | output | CNT_W | Number of frames dropped |

## Verification
The hardest case to reach from the ports is a frame that is already being dropped when software re-arms the engine partway through it. The engine becomes ready while bytes of that frame are still arriving, and those bytes must not start a capture. The bench first makes a descriptor owned by software, so that the engine stops. It then starts a frame and pulses `act_set` in parallel after a few bytes. Finally it checks that the count rises once, that the descriptor is untouched, and that the next whole frame lands in that same descriptor.

// File: rtl/rxr_pkg.sv
// Shared definitions for the receive descriptor ring engine:
// status bit positions, controller states and the write-back flag set.
package rxr_pkg;

    localparam int ST_EMPTY = 15;
    localparam int ST_WRAP  = 13;
    localparam int ST_LAST  = 11;
    localparam int ST_LONG  = 5;
    localparam int ST_ERR   = 2;
    localparam int ST_TRUNC = 0;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_STAT,
        S_CHK_STAT,
        S_GET_PTR,
        S_ARMED,
        S_FRAME,
        S_WB_LEN,
        S_WB_STAT
    } ctl_state_t;

    typedef struct packed {
        logic err;
        logic too_long;
        logic trunc;
    } rx_flags_t;

    // Build the status half-word written back at the end of a frame.
    function automatic logic [15:0] wb_status(input logic wrap, input rx_flags_t f);
        logic [15:0] s;
        s           = '0;
        s[ST_WRAP]  = wrap;
        s[ST_LAST]  = 1'b1;
        s[ST_LONG]  = f.too_long;
        s[ST_ERR]   = f.err;
        s[ST_TRUNC] = f.trunc;
        return s;
    endfunction

endpackage

// File: rtl/rxr_gate.sv
// Frame admission and drop accounting.
// A frame is admitted only if its first byte arrives while the engine is
// ready. A frame whose first byte is refused stays refused to its last byte.
// Assumes rx_last marks the final byte of every frame.
module rxr_gate #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_en,
    input  logic             rx_valid,
    input  logic             rx_last,
    input  logic             armed,
    input  logic             in_frame,
    output logic             take,
    output logic             start,
    output logic [CNT_W-1:0] drop_cnt
);

    logic drop_mid;
    logic dropped;

    // Decide whether the current byte belongs to a captured frame.
    always_comb begin
        take    = rx_valid && ctrl_en && (in_frame || (armed && !drop_mid));
        start   = take && !in_frame;
        dropped = rx_valid && ctrl_en && !take;
    end

    // Track a frame being discarded and count it at its last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drop_mid <= 1'b0;
            drop_cnt <= '0;
        end else if (!ctrl_en) begin
            drop_mid <= 1'b0;
        end else if (dropped) begin
            drop_mid <= !rx_last;
            if (rx_last) drop_cnt <= drop_cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/rxr_pack.sv
// Byte-to-word packer for one frame.
// It assembles bytes little-endian and issues one buffer write per full word
// or for the partial final word. It counts stored and received bytes and
// keeps the error, length and truncation flags.
// Assumes buf_size is a multiple of 4 and at most one byte per cycle.
module rxr_pack #(
    parameter int AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_en,
    input  logic              take,
    input  logic              start,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    input  logic              rx_err,
    input  logic [AW-1:0]     buf_word,
    input  logic [15:0]       buf_size,
    input  logic [15:0]       max_flen,
    output logic              wr_vld,
    output logic [AW-1:0]     wr_addr,
    output logic [31:0]       wr_data,
    output logic [3:0]        wr_be,
    output logic [15:0]       stored_len,
    output rxr_pkg::rx_flags_t flags
);
    import rxr_pkg::*;

    logic [15:0] scnt, tcnt;
    logic [31:0] asm_d;
    logic [3:0]  asm_be;

    logic [15:0] base_s, base_t, nt;
    logic [31:0] base_d, nd;
    logic [3:0]  base_be, nbe;
    rx_flags_t   base_f;
    logic        store, push;
    logic [1:0]  lane;

    // Merge the incoming byte into the word under assembly.
    always_comb begin
        base_s  = start ? 16'd0 : scnt;
        base_t  = start ? 16'd0 : tcnt;
        base_d  = start ? 32'd0 : asm_d;
        base_be = start ? 4'd0  : asm_be;
        base_f  = start ? '0    : flags;
        store   = base_s < buf_size;
        lane    = base_s[1:0];
        nd      = base_d;
        nbe     = base_be;
        if (store) begin
            nd[{lane, 3'b000} +: 8] = rx_data;
            nbe[lane]               = 1'b1;
        end
        nt   = (base_t == 16'hFFFF) ? base_t : base_t + 16'd1;
        push = store && ((lane == 2'd3) || rx_last);
    end

    // Register counters, flags and the outgoing word write.
    always_ff @(posedge clk) begin
        if (!rst_n || !ctrl_en) begin
            wr_vld  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            wr_be   <= '0;
            scnt    <= '0;
            tcnt    <= '0;
            asm_d   <= '0;
            asm_be  <= '0;
            flags   <= '0;
        end else begin
            wr_vld <= take && push;
            if (take) begin
                scnt           <= base_s + {15'd0, store};
                tcnt           <= nt;
                flags.err      <= base_f.err | rx_err;
                flags.trunc    <= base_f.trunc | !store;
                flags.too_long <= nt > max_flen;
                if (push) begin
                    wr_addr <= buf_word + AW'(base_s[15:2]);
                    wr_data <= nd;
                    wr_be   <= nbe;
                    asm_d   <= '0;
                    asm_be  <= '0;
                end else begin
                    asm_d   <= nd;
                    asm_be  <= nbe;
                end
            end
        end
    end

    assign stored_len = scnt;

endmodule

// File: rtl/rxr_ctrl.sv
// Descriptor sequencer: active flag, ring index, descriptor fetch,
// length then status write-back, and advance with wrap.
// It uses the memory port only while the packer is not writing.
// Assumes read data arrives one cycle after the request and AW <= 30.
module rxr_ctrl #(
    parameter int AW = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_en,
    input  logic               act_set,
    input  logic [AW-1:0]      ring_base,
    input  logic               take,
    input  logic               rx_last,
    input  logic               port_busy,
    input  logic [31:0]        mem_rdata,
    input  logic [15:0]        stored_len,
    input  rxr_pkg::rx_flags_t flags,
    output logic               act,
    output logic               armed,
    output logic               in_frame,
    output logic [AW-1:0]      buf_word,
    output logic               c_req,
    output logic               c_we,
    output logic [AW-1:0]      c_addr,
    output logic [3:0]         c_be,
    output logic [31:0]        c_wdata
);
    import rxr_pkg::*;

    ctl_state_t    state;
    logic [AW-1:0] desc_addr;
    logic          desc_wrap;
    logic          rd_empty, rd_wrap;
    logic          unused_rdata;

    assign rd_empty     = mem_rdata[16 + ST_EMPTY];
    assign rd_wrap      = mem_rdata[16 + ST_WRAP];
    assign unused_rdata = ^mem_rdata;
    assign armed        = (state == S_ARMED);
    assign in_frame     = (state == S_FRAME);

    // Drive this sequencer's memory request for the current state.
    always_comb begin
        c_req   = 1'b0;
        c_we    = 1'b0;
        c_addr  = desc_addr;
        c_be    = 4'b0000;
        c_wdata = 32'd0;
        case (state)
            S_RD_STAT: c_req = 1'b1;
            S_CHK_STAT: if (rd_empty) begin
                c_req  = 1'b1;
                c_addr = desc_addr + AW'(1);
            end
            S_WB_LEN: if (!port_busy) begin
                c_req   = 1'b1;
                c_we    = 1'b1;
                c_be    = 4'b0011;
                c_wdata = {16'd0, stored_len};
            end
            S_WB_STAT: if (!port_busy) begin
                c_req   = 1'b1;
                c_we    = 1'b1;
                c_be    = 4'b1100;
                c_wdata = {wb_status(desc_wrap, flags), 16'd0};
            end
            default: ;
        endcase
    end

    // Keep the active flag: set by software, cleared on a busy descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n || !ctrl_en)
            act <= 1'b0;
        else if (act_set)
            act <= 1'b1;
        else if (state == S_CHK_STAT && !rd_empty)
            act <= 1'b0;
    end

    // Sequence the states and move the ring index.
    always_ff @(posedge clk) begin
        if (!rst_n || !ctrl_en) begin
            state     <= S_IDLE;
            desc_addr <= ring_base;
            desc_wrap <= 1'b0;
            buf_word  <= '0;
        end else begin
            case (state)
                S_IDLE:     if (act) state <= S_RD_STAT;
                S_RD_STAT:  state <= S_CHK_STAT;
                S_CHK_STAT: begin
                    desc_wrap <= rd_wrap;
                    state     <= rd_empty ? S_GET_PTR : S_IDLE;
                end
                S_GET_PTR: begin
                    buf_word <= mem_rdata[AW+1:2];
                    state    <= S_ARMED;
                end
                S_ARMED:    if (take) state <= rx_last ? S_WB_LEN : S_FRAME;
                S_FRAME:    if (take && rx_last) state <= S_WB_LEN;
                S_WB_LEN:   if (!port_busy) state <= S_WB_STAT;
                S_WB_STAT:  if (!port_busy) begin
                    desc_addr <= desc_wrap ? ring_base : desc_addr + AW'(2);
                    state     <= S_RD_STAT;
                end
                default:    state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rx_ring_dma.sv
// Receive descriptor ring DMA engine, top level.
// It joins the admission gate, the byte packer and the descriptor sequencer,
// and shares one memory port between them. Buffer data writes take priority
// on that port.
// Assumes a memory that grants every request at once.
module rx_ring_dma #(
    parameter int AW    = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_en,
    input  logic             act_set,
    input  logic [AW-1:0]    ring_base,
    input  logic [15:0]      buf_size,
    input  logic [15:0]      max_flen,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             rx_last,
    input  logic             rx_err,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [3:0]       mem_be,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata,
    output logic             act,
    output logic [CNT_W-1:0] drop_cnt
);
    import rxr_pkg::*;

    logic          take, start, armed, in_frame;
    logic          pk_vld;
    logic [AW-1:0] pk_addr, buf_word;
    logic [31:0]   pk_data;
    logic [3:0]    pk_be;
    logic [15:0]   stored_len;
    rx_flags_t     flags;
    logic          c_req, c_we;
    logic [AW-1:0] c_addr;
    logic [3:0]    c_be;
    logic [31:0]   c_wdata;

    rxr_gate #(.CNT_W(CNT_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en),
        .rx_valid(rx_valid), .rx_last(rx_last),
        .armed(armed), .in_frame(in_frame),
        .take(take), .start(start), .drop_cnt(drop_cnt)
    );

    rxr_pack #(.AW(AW)) u_pack (
        .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en),
        .take(take), .start(start),
        .rx_data(rx_data), .rx_last(rx_last), .rx_err(rx_err),
        .buf_word(buf_word), .buf_size(buf_size), .max_flen(max_flen),
        .wr_vld(pk_vld), .wr_addr(pk_addr), .wr_data(pk_data), .wr_be(pk_be),
        .stored_len(stored_len), .flags(flags)
    );

    rxr_ctrl #(.AW(AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .act_set(act_set),
        .ring_base(ring_base), .take(take), .rx_last(rx_last),
        .port_busy(pk_vld), .mem_rdata(mem_rdata),
        .stored_len(stored_len), .flags(flags),
        .act(act), .armed(armed), .in_frame(in_frame), .buf_word(buf_word),
        .c_req(c_req), .c_we(c_we), .c_addr(c_addr), .c_be(c_be), .c_wdata(c_wdata)
    );

    // Share the memory port; buffer data writes win.
    always_comb begin
        if (pk_vld) begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = pk_addr;
            mem_be    = pk_be;
            mem_wdata = pk_data;
        end else begin
            mem_req   = c_req;
            mem_we    = c_we;
            mem_addr  = c_addr;
            mem_be    = c_be;
            mem_wdata = c_wdata;
        end
    end

endmodule

// File: rtl/rxr_checker.sv
// Temporal checks on the engine's ports, attached to the top by bind.
module rxr_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctrl_en,
    input logic             act,
    input logic             mem_req,
    input logic             mem_we,
    input logic [3:0]       mem_be,
    input logic [31:0]      mem_wdata,
    input logic [CNT_W-1:0] drop_cnt,
    input logic             rx_valid,
    input logic             rx_last
);

    // R3
    len_before_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_be == 4'b1100) |-> $past(mem_req && mem_we && mem_be == 4'b0011));

    // R4
    stat_owner_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_be == 4'b1100) |-> (!mem_wdata[31] && mem_wdata[27]));

    // R10
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |=> (!act && !mem_req));

    // R6
    stop_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(act) |-> !(mem_req && mem_we));

    // R7
    drop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_cnt != $past(drop_cnt)) |->
            ((drop_cnt == $past(drop_cnt) + CNT_W'(1)) && $past(rx_valid && rx_last)));

endmodule

bind rx_ring_dma rxr_checker #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/rx_ring_dma_tb.sv
module rx_ring_dma_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 10;
    localparam int CNT_W = 16;
    localparam int RB    = 16;
    localparam int BUFW  = 256;
    localparam int BSTR  = 32;

    logic             clk = 1'b0;
    logic             rst_n, ctrl_en, act_set;
    logic [AW-1:0]    ring_base;
    logic [15:0]      buf_size, max_flen;
    logic             rx_valid, rx_last, rx_err;
    logic [7:0]       rx_data;
    logic             mem_req, mem_we, act;
    logic [AW-1:0]    mem_addr;
    logic [3:0]       mem_be;
    logic [31:0]      mem_wdata, mem_rdata;
    logic [CNT_W-1:0] drop_cnt;

    logic [31:0] mem [0:(1<<AW)-1];
    logic          tb_wr = 1'b0;
    logic [AW-1:0] tb_addr = '0;
    logic [31:0]   tb_wd = '0;

    int checks = 0, errors = 0;
    int nd = 0;
    logic [3:0] last_be = 4'h0, prev_be = 4'h0;
    int late = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_ring_dma #(.AW(AW), .CNT_W(CNT_W)) u_dut (.*);

    // Memory model: one-cycle read latency, byte-enabled writes, bench pokes.
    always @(posedge clk) begin
        if (tb_wr) mem[tb_addr] <= tb_wd;
        else if (mem_req && mem_we) begin
            for (int b = 0; b < 4; b++)
                if (mem_be[b]) mem[mem_addr][b*8 +: 8] <= mem_wdata[b*8 +: 8];
        end else if (mem_req) mem_rdata <= mem[mem_addr];
    end

    // Write-order monitor for the descriptor area.
    always @(posedge clk) begin
        if (mem_req && mem_we) begin
            if (int'(mem_addr) >= RB && int'(mem_addr) < RB + 8) begin
                prev_be <= last_be;
                last_be <= mem_be;
                if (mem_be == 4'hC) late <= 0;
            end else late <= late + 1;
        end
    end

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, got, exp);
        end
    endtask

    function automatic logic [7:0] fb(input int id, input int k);
        return 8'(id * 37 + k * 5 + 3);
    endfunction

    task automatic poke(input int a, input logic [31:0] d);
        @(negedge clk);
        tb_wr = 1'b1; tb_addr = AW'(a); tb_wd = d;
        @(negedge clk);
        tb_wr = 1'b0;
    endtask

    task automatic init_desc(input int i, input bit empty);
        logic [15:0] st;
        st = (empty ? 16'h8000 : 16'h0) | ((i == 3) ? 16'h2000 : 16'h0);
        poke(RB + 2*i, {st, 16'h0});
        poke(RB + 2*i + 1, 32'((BUFW + i*BSTR) * 4));
        for (int w = 0; w < 18; w++) poke(BUFW + i*BSTR + w, 32'hA5A5A5A5);
    endtask

    task automatic send_frame(input int len, input bit err, input int id);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = fb(id, k);
            rx_last = (k == len - 1); rx_err = err && (k == len - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0;
    endtask

    function automatic logic [7:0] buf_byte(input int d, input int k);
        return mem[BUFW + d*BSTR + k/4][(k%4)*8 +: 8];
    endfunction

    // Send a frame expected to land in descriptor nd, check it, recycle it.
    task automatic run_frame(input int len, input bit err, input int id);
        int exp_len, mism;
        logic [15:0] est;
        send_frame(len, err, id);
        repeat (14) @(negedge clk);
        exp_len = (len > int'(buf_size)) ? int'(buf_size) : len;
        est = ((nd == 3) ? 16'h2000 : 16'h0) | 16'h0800 | (err ? 16'h0004 : 16'h0)
            | ((len > int'(max_flen)) ? 16'h0020 : 16'h0) | ((len > int'(buf_size)) ? 16'h0001 : 16'h0);
        chk($sformatf("R3 R8 length id=%0d", id), {16'h0, mem[RB + 2*nd][15:0]}, 32'(exp_len));
        chk($sformatf("R4 R5 R9 status id=%0d desc=%0d", id, nd), {16'h0, mem[RB + 2*nd][31:16]}, {16'h0, est});
        mism = 0;
        for (int k = 0; k < exp_len; k++) if (buf_byte(nd, k) !== fb(id, k)) mism++;
        chk($sformatf("R2 payload id=%0d", id), 32'(mism), 32'd0);
        chk($sformatf("R2 R8 byte past end id=%0d", id), {24'h0, buf_byte(nd, exp_len)}, 32'hA5);
        chk($sformatf("R3 write order id=%0d", id), {24'h0, prev_be, last_be}, 32'h3C);
        chk($sformatf("R3 no late write id=%0d", id), 32'(late), 32'd0);
        init_desc(nd, 1'b1);
        nd = (nd + 1) % 4;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog R1..all actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ctrl_en = 1'b0; act_set = 1'b0;
        ring_base = AW'(RB); buf_size = 16'd64; max_flen = 16'd60;
        rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0; rx_data = 8'h0;
        for (int i = 0; i < 4; i++) init_desc(i, 1'b1);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 act after reset", {31'h0, act}, 32'h0);
        chk("R1 drop_cnt after reset", 32'(drop_cnt), 32'h0);
        chk("R1 mem_req after reset", {31'h0, mem_req}, 32'h0);

        ctrl_en = 1'b1;
        @(negedge clk); act_set = 1'b1; @(negedge clk); act_set = 1'b0;
        repeat (6) @(negedge clk);
        chk("R2 act raised", {31'h0, act}, 32'h1);

        // Length sweep across the buffer and frame-length limits.
        for (int len = 1; len <= 70; len++) run_frame(len, (len % 7) == 0, len);

        // Busy descriptor after the next one: engine must stop.
        poke(RB + 2*((nd + 1) % 4), 32'h2000_0000);
        run_frame(10, 1'b0, 100);
        chk("R6 act cleared on busy descriptor", {31'h0, act}, 32'h0);
        send_frame(10, 1'b0, 101);
        repeat (6) @(negedge clk);
        chk("R7 drop counted", 32'(drop_cnt), 32'd1);
        chk("R6 R7 busy descriptor untouched", mem[RB + 2*nd], 32'h2000_0000);

        // Re-arm partway through a dropped frame.
        poke(RB + 2*nd, 32'hA000_0000);
        fork
            send_frame(20, 1'b0, 102);
            begin repeat (4) @(negedge clk); act_set = 1'b1; @(negedge clk); act_set = 1'b0; end
        join
        repeat (6) @(negedge clk);
        chk("R7 mid-frame re-arm still drops", 32'(drop_cnt), 32'd2);
        chk("R7 descriptor untouched by dropped frame", mem[RB + 2*nd], 32'hA000_0000);
        chk("R6 act after resume", {31'h0, act}, 32'h1);
        run_frame(9, 1'b0, 103);
        run_frame(5, 1'b1, 104);

        // Disable: index returns to ring base, frames ignored.
        ctrl_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 act low while disabled", {31'h0, act}, 32'h0);
        send_frame(8, 1'b0, 105);
        repeat (4) @(negedge clk);
        chk("R10 frame ignored not counted", 32'(drop_cnt), 32'd2);
        chk("R10 no memory request", {31'h0, mem_req}, 32'h0);
        ctrl_en = 1'b1;
        @(negedge clk); act_set = 1'b1; @(negedge clk); act_set = 1'b0;
        repeat (6) @(negedge clk);
        nd = 0;
        run_frame(6, 1'b0, 106);
        chk("R10 R5 desc one untouched", mem[RB + 2], 32'h8000_0000);

        // Small buffer sweep around the truncation boundary.
        buf_size = 16'd8; max_flen = 16'd1518;
        for (int len = 1; len <= 12; len++) run_frame(len, 1'b0, 200 + len);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule